// File: doc/BRIEF.md
# Four-Byte-Address Serial Flash Command Sequencer

This block turns one high-level flash request into the SPI transactions a serial NOR flash expects when addresses are 32 bits wide. A request carries a kind (read, page program, 4 KB / 32 KB / 64 KB erase, or entry into four-byte addressing), a 32-bit address, a length and, for programs, a byte stream. The block drives a single-lane SPI master port in mode 0. It places the opcode, four address bytes and any payload in one chip-select frame. Write-type requests are preceded by a frame holding only a write-enable.

Each request also carries an opcode-set select. With `req_direct` high, the block uses the opcodes that always take a four-byte address. With it low, it uses the older opcodes, which take four address bytes once the device is already in four-byte mode. After an erase, the block waits a poll interval that depends on the erase size, with chip select high. It then reads the status register and repeats the wait-and-read until the write-in-progress flag is clear. Read data returns one byte at a time on a valid-qualified output. Program data is pulled from the requester with a one-cycle take strobe.

Top module: `sf4_cmd_seq`

## Requirements
- R1: With `req_direct`=1 the first byte of the main frame is 0x13 for read (kind 0), 0x12 for program (kind 1), 0x21 for 4 KB erase (kind 2), 0x5C for 32 KB erase (kind 3) and 0xDC for 64 KB erase (kind 4).
- R2: With `req_direct`=0 the main-frame opcode is 0x03, 0x02, 0x20, 0x52 or 0xD8 for kinds 0 to 4 respectively, and four address bytes still follow it.
- R3: The four address bytes come directly after the opcode, most significant byte first.
- R4: Program and erase requests first send a separate frame holding only 0x06; chip select goes high for at least `CS_GAP` cycles before the main frame.
- R5: Kind 5 sends one frame holding only 0xB7. Kind 6 sends a 0x06 frame first and then the 0xB7 frame. Neither request depends on `req_direct`.
- R6: A program request with length 0 or above 256, or any request of kind 7, is rejected. `done` and `err` pulse on the cycle after acceptance, `busy` stays low and chip select never goes low.
- R7: A program frame carries exactly `req_len` payload bytes after the address, in the order they are taken. `wr_take` pulses once per byte.
- R8: A read frame sends 0x00 for each of `req_len` bytes after the address and returns the bytes sampled from MISO in order on `rd_byte` with one `rd_valid` pulse each. A length of 0 ends the frame after the address.
- R9: After an erase frame, chip select stays high for the poll interval (`POLL_SHORT` cycles for 4 KB, `POLL_LONG` for 32/64 KB). The block then sends a frame of 0x05 plus one read byte. While bit 0 of that byte is 1 the wait and read repeat; the request completes after the first read with bit 0 clear.
- R10: SPI mode 0: SCK is low whenever chip select is high, MOSI only changes while SCK is low, and bytes are sent MSB first.
- R11: `busy` is high from acceptance until the cycle `done` pulses. `done` lasts one cycle. A request presented while `busy` is high is ignored.
- R12: After reset, `cs_n`=1, `sck`=0, `busy`=0, `done`=0 and `err`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_kind | input | 3 | 0 read, 1 program, 2/3/4 erase 4K/32K/64K, 5 enter 4-byte, 6 enter with write-enable |
| req_direct | input | 1 | 1 selects the dedicated four-byte opcode set |
| req_addr | input | 32 | Byte address |
| req_len | input | LEN_W | Byte count for read or program |
| wr_byte | input | 8 | Current program data byte |
| wr_take | output | 1 | Pulse: `wr_byte` was captured, present the next one |
| rd_byte | output | 8 | Received read byte |
| rd_valid | output | 1 | Pulse qualifying `rd_byte` |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Rejection flag, pulses with `done` |
| sck | output | 1 | SPI clock |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data out |
| miso | input | 1 | SPI data in |

## Verification
The bound checker watches the properties that hold on every cycle: SCK stays low outside a frame, MOSI holds while SCK is high, and `done` is a single pulse that coincides with the fall of `busy` unless it carries `err`. It also checks that `rd_valid` and `wr_take` occur only while busy. Frame contents can only be shown by the bench's scenarios, against a flash model that records every chip-select frame. These include opcode choice per set, address byte order, payload length and order, the poll interval and repeat count, and the rejection of bad lengths. The ignoring of a request presented while busy is also shown there.

// File: rtl/sf4_pkg.sv
package sf4_pkg;

    typedef enum logic [2:0] {
        K_READ     = 3'd0,
        K_PROG     = 3'd1,
        K_ER4K     = 3'd2,
        K_ER32K    = 3'd3,
        K_ER64K    = 3'd4,
        K_ENTER    = 3'd5,
        K_ENTER_WE = 3'd6,
        K_BAD      = 3'd7
    } req_kind_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_WEN, ST_GAP, ST_CMD, ST_ADDR,
        ST_WDATA, ST_RDATA, ST_WAIT, ST_STAT, ST_DONE
    } seq_state_e;

    typedef struct packed {
        req_kind_e   kind;
        logic        direct;
        logic [31:0] addr;
    } seq_req_t;

    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_RDSR   = 8'h05;
    localparam logic [7:0] OP_ENTER4 = 8'hB7;
    localparam int         SR_WIP    = 0;

    function automatic logic [7:0] cmd_opcode(req_kind_e k, logic direct);
        logic [7:0] op;
        case (k)
            K_READ:  op = direct ? 8'h13 : 8'h03;
            K_PROG:  op = direct ? 8'h12 : 8'h02;
            K_ER4K:  op = direct ? 8'h21 : 8'h20;
            K_ER32K: op = direct ? 8'h5C : 8'h52;
            K_ER64K: op = direct ? 8'hDC : 8'hD8;
            default: op = OP_ENTER4;
        endcase
        return op;
    endfunction

    function automatic logic needs_wren(req_kind_e k);
        return (k == K_PROG) || (k == K_ER4K) || (k == K_ER32K) ||
               (k == K_ER64K) || (k == K_ENTER_WE);
    endfunction

    function automatic logic is_erase(req_kind_e k);
        return (k == K_ER4K) || (k == K_ER32K) || (k == K_ER64K);
    endfunction

    function automatic logic is_enter(req_kind_e k);
        return (k == K_ENTER) || (k == K_ENTER_WE);
    endfunction

    function automatic logic [7:0] addr_byte(logic [31:0] a, logic [1:0] i);
        logic [31:0] s;
        s = a << {i, 3'b000};
        return s[31:24];
    endfunction

endpackage

// File: rtl/sf4_spi_byte.sv
module sf4_spi_byte (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic [7:0] rx,
    output logic       done
);
    logic       active;
    logic [2:0] bit_cnt;
    logic [7:0] sh_tx;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            bit_cnt <= '0;
            sh_tx   <= '0;
            rx      <= '0;
            sck     <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                active  <= 1'b1;
                bit_cnt <= '0;
                sh_tx   <= tx;
                sck     <= 1'b0;
            end else if (active) begin
                if (!sck) begin
                    sck <= 1'b1;
                    rx  <= {rx[6:0], miso};
                end else begin
                    sck <= 1'b0;
                    if (bit_cnt == 3'd7) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 3'd1;
                        sh_tx   <= {sh_tx[6:0], 1'b0};
                    end
                end
            end
        end
    end

    assign mosi = sh_tx[7];

endmodule

// File: rtl/sf4_interval.sv
module sf4_interval #(
    parameter int SHORT_CYC = 2000000,
    parameter int LONG_CYC  = 20000000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic sel_long,
    output logic expired
);
    localparam int CW = $clog2(LONG_CYC + 1);
    localparam logic [CW-1:0] SHORT_M1 = CW'(SHORT_CYC - 1);
    localparam logic [CW-1:0] LONG_M1  = CW'(LONG_CYC - 1);

    logic [CW-1:0] cnt;
    logic          run;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (load) begin
            cnt <= sel_long ? LONG_M1 : SHORT_M1;
            run <= 1'b1;
        end else if (run) begin
            if (cnt == '0) run <= 1'b0;
            else           cnt <= cnt - CW'(1);
        end
    end

    assign expired = run && (cnt == '0);

endmodule

// File: rtl/sf4_cmd_seq.sv
module sf4_cmd_seq
    import sf4_pkg::*;
#(
    parameter int LEN_W      = 10,
    parameter int CS_GAP     = 2,
    parameter int POLL_SHORT = 2000000,
    parameter int POLL_LONG  = 20000000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [2:0]       req_kind,
    input  logic             req_direct,
    input  logic [31:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic [7:0]       wr_byte,
    output logic             wr_take,
    output logic [7:0]       rd_byte,
    output logic             rd_valid,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             sck,
    output logic             cs_n,
    output logic             mosi,
    input  logic             miso
);
    localparam int MAX_PROG = 256;
    localparam int GAP_W    = $clog2(CS_GAP + 1);
    localparam logic [LEN_W-1:0] PROG_LIM = LEN_W'(MAX_PROG);
    localparam logic [GAP_W-1:0] GAP_END  = GAP_W'(CS_GAP - 1);

    seq_state_e       state;
    seq_req_t         rq;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] cnt_q;
    logic [1:0]       idx_q;
    logic [GAP_W-1:0] gap_q;
    logic             start_q;
    logic [7:0]       tx_q;
    logic             tmr_load;
    logic             tmr_long;
    logic             tmr_exp;
    logic             eng_done;
    logic [7:0]       eng_rx;
    req_kind_e        in_kind;
    logic             in_bad;

    always_comb begin
        in_kind = req_kind_e'(req_kind);
        in_bad  = (in_kind == K_BAD) ||
                  ((in_kind == K_PROG) && ((req_len == '0) || (req_len > PROG_LIM)));
    end

    sf4_spi_byte u_byte (
        .clk   (clk),
        .rst   (rst),
        .start (start_q),
        .tx    (tx_q),
        .miso  (miso),
        .sck   (sck),
        .mosi  (mosi),
        .rx    (eng_rx),
        .done  (eng_done)
    );

    sf4_interval #(
        .SHORT_CYC (POLL_SHORT),
        .LONG_CYC  (POLL_LONG)
    ) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .sel_long (tmr_long),
        .expired  (tmr_exp)
    );

    assign tmr_long = (rq.kind != K_ER4K);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            rq       <= '0;
            len_q    <= '0;
            cnt_q    <= '0;
            idx_q    <= '0;
            gap_q    <= '0;
            start_q  <= 1'b0;
            tx_q     <= '0;
            tmr_load <= 1'b0;
            busy     <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
            cs_n     <= 1'b1;
            wr_take  <= 1'b0;
            rd_valid <= 1'b0;
            rd_byte  <= '0;
        end else begin
            start_q  <= 1'b0;
            tmr_load <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
            wr_take  <= 1'b0;
            rd_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (in_bad) begin
                            done <= 1'b1;
                            err  <= 1'b1;
                        end else begin
                            rq.kind   <= in_kind;
                            rq.direct <= req_direct;
                            rq.addr   <= req_addr;
                            len_q     <= req_len;
                            busy      <= 1'b1;
                            cs_n      <= 1'b0;
                            start_q   <= 1'b1;
                            if (needs_wren(in_kind)) begin
                                tx_q  <= OP_WREN;
                                state <= ST_WEN;
                            end else begin
                                tx_q  <= cmd_opcode(in_kind, req_direct);
                                state <= ST_CMD;
                            end
                        end
                    end
                end
                ST_WEN: begin
                    if (eng_done) begin
                        cs_n  <= 1'b1;
                        gap_q <= '0;
                        state <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (gap_q == GAP_END) begin
                        cs_n    <= 1'b0;
                        start_q <= 1'b1;
                        tx_q    <= cmd_opcode(rq.kind, rq.direct);
                        state   <= ST_CMD;
                    end else begin
                        gap_q <= gap_q + GAP_W'(1);
                    end
                end
                ST_CMD: begin
                    if (eng_done) begin
                        if (is_enter(rq.kind)) begin
                            cs_n  <= 1'b1;
                            state <= ST_DONE;
                        end else begin
                            idx_q   <= 2'd0;
                            start_q <= 1'b1;
                            tx_q    <= addr_byte(rq.addr, 2'd0);
                            state   <= ST_ADDR;
                        end
                    end
                end
                ST_ADDR: begin
                    if (eng_done) begin
                        if (idx_q != 2'd3) begin
                            idx_q   <= idx_q + 2'd1;
                            start_q <= 1'b1;
                            tx_q    <= addr_byte(rq.addr, idx_q + 2'd1);
                        end else if (rq.kind == K_PROG) begin
                            start_q <= 1'b1;
                            tx_q    <= wr_byte;
                            wr_take <= 1'b1;
                            cnt_q   <= LEN_W'(1);
                            state   <= ST_WDATA;
                        end else if (rq.kind == K_READ) begin
                            if (len_q == '0) begin
                                cs_n  <= 1'b1;
                                state <= ST_DONE;
                            end else begin
                                start_q <= 1'b1;
                                tx_q    <= 8'h00;
                                cnt_q   <= '0;
                                state   <= ST_RDATA;
                            end
                        end else begin
                            cs_n     <= 1'b1;
                            tmr_load <= 1'b1;
                            state    <= ST_WAIT;
                        end
                    end
                end
                ST_WDATA: begin
                    if (eng_done) begin
                        if (cnt_q == len_q) begin
                            cs_n  <= 1'b1;
                            state <= ST_DONE;
                        end else begin
                            start_q <= 1'b1;
                            tx_q    <= wr_byte;
                            wr_take <= 1'b1;
                            cnt_q   <= cnt_q + LEN_W'(1);
                        end
                    end
                end
                ST_RDATA: begin
                    if (eng_done) begin
                        rd_valid <= 1'b1;
                        rd_byte  <= eng_rx;
                        if (cnt_q == len_q - LEN_W'(1)) begin
                            cs_n  <= 1'b1;
                            state <= ST_DONE;
                        end else begin
                            start_q <= 1'b1;
                            tx_q    <= 8'h00;
                            cnt_q   <= cnt_q + LEN_W'(1);
                        end
                    end
                end
                ST_WAIT: begin
                    if (tmr_exp) begin
                        cs_n    <= 1'b0;
                        start_q <= 1'b1;
                        tx_q    <= OP_RDSR;
                        idx_q   <= 2'd0;
                        state   <= ST_STAT;
                    end
                end
                ST_STAT: begin
                    if (eng_done) begin
                        if (idx_q == 2'd0) begin
                            idx_q   <= 2'd1;
                            start_q <= 1'b1;
                            tx_q    <= 8'h00;
                        end else begin
                            cs_n <= 1'b1;
                            if (eng_rx[SR_WIP]) begin
                                tmr_load <= 1'b1;
                                state    <= ST_WAIT;
                            end else begin
                                state <= ST_DONE;
                            end
                        end
                    end
                end
                ST_DONE: begin
                    busy  <= 1'b0;
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sf4_seq_checker.sv
module sf4_seq_checker (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic done,
    input logic err,
    input logic cs_n,
    input logic sck,
    input logic mosi,
    input logic rd_valid,
    input logic wr_take
);
    // R10: clock only toggles inside a frame
    a_r10_sck_low_outside_frame: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sck);

    // R10: data held while the clock is high
    a_r10_mosi_stable_high: assert property (@(posedge clk) disable iff (rst)
        sck |-> $stable(mosi));

    // R11: completion is a single-cycle pulse
    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11: a normal completion ends the busy window
    a_r11_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        (done && !err) |-> $fell(busy));

    // R6: rejection flag only together with completion
    a_r6_err_with_done: assert property (@(posedge clk) disable iff (rst)
        err |-> (done && !busy));

    // R11: no frame activity while idle
    a_r11_idle_cs_high: assert property (@(posedge clk) disable iff (rst)
        !busy |-> cs_n);

    // R8: returned bytes belong to an active request
    a_r8_rd_in_busy: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> busy);

    // R7: payload takes belong to an active request
    a_r7_take_in_busy: assert property (@(posedge clk) disable iff (rst)
        wr_take |-> busy);
endmodule

bind sf4_cmd_seq sf4_seq_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .cs_n     (cs_n),
    .sck      (sck),
    .mosi     (mosi),
    .rd_valid (rd_valid),
    .wr_take  (wr_take)
);

// File: tb/tb_sf4_cmd_seq.sv
`timescale 1ns/1ps
module tb_sf4_cmd_seq;
    localparam int LEN_W = 10;
    localparam int PS    = 40;
    localparam int PL    = 120;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [2:0] req_kind = '0;
    logic req_direct = 1'b0;
    logic [31:0] req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic [7:0] wr_byte;
    logic wr_take, rd_valid, busy, done, err, sck, cs_n, mosi;
    logic [7:0] rd_byte;
    logic miso_r = 1'b0;

    always #2.5 clk = ~clk;

    sf4_cmd_seq #(.LEN_W(LEN_W), .CS_GAP(2), .POLL_SHORT(PS), .POLL_LONG(PL)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_direct(req_direct), .req_addr(req_addr), .req_len(req_len),
        .wr_byte(wr_byte), .wr_take(wr_take), .rd_byte(rd_byte), .rd_valid(rd_valid),
        .busy(busy), .done(done), .err(err), .sck(sck), .cs_n(cs_n),
        .mosi(mosi), .miso(miso_r)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] fhash(logic [31:0] h, logic [7:0] b);
        return {h[26:0], h[31:27]} ^ ({24'h0, b} + 32'd1);
    endfunction

    function automatic logic [7:0] rpat(logic [31:0] a, int k);
        return 8'(k * 7 + 60) ^ a[7:0];
    endfunction

    // program data source
    logic [7:0] pdata [0:299];
    int pidx = 0;
    assign wr_byte = pdata[pidx];
    always @(posedge clk) if (wr_take) pidx <= pidx + 1;

    // expected frames (scoreboard)
    int          ex_len [$];
    logic [31:0] ex_hash[$];
    string       ex_tag [$];
    logic [7:0]  ex_rd  [$];
    int fl;
    logic [31:0] fh;
    int exp_gap = 0;

    task automatic fr_begin(); fl = 0; fh = 32'h1; endtask
    task automatic fr_add(logic [7:0] b); fl++; fh = fhash(fh, b); endtask
    task automatic fr_push(string tag);
        ex_len.push_back(fl); ex_hash.push_back(fh); ex_tag.push_back(tag);
    endtask
    task automatic fr_addr(logic [31:0] a);
        for (int i = 3; i >= 0; i--) fr_add(a[8*i +: 8]);
    endtask
    task automatic exp_wren(string tag);
        fr_begin(); fr_add(8'h06); fr_push(tag);
    endtask
    task automatic exp_status(int n);
        for (int i = 0; i < n; i++) begin
            fr_begin(); fr_add(8'h05); fr_add(8'h00); fr_push("R9");
        end
    endtask

    // flash model
    logic [7:0] sb [0:299];
    int sn = 0, bits = 0, frames_seen = 0, cs_falls = 0, busy_left = 0;
    logic [7:0] cur;
    logic [31:0] sh;
    bit in_frame = 0;
    int hi_run = 0, last_gap = 0;

    always @(negedge cs_n) begin
        in_frame = 1; sn = 0; bits = 0; cur = 0; sh = 32'h1; miso_r = 1'b0;
        cs_falls++;
    end

    always @(posedge sck) if (!cs_n) begin
        cur = {cur[6:0], mosi};
        bits++;
        if (bits % 8 == 0) begin
            if (sn < 300) sb[sn] = cur;
            sn++;
            sh = fhash(sh, cur);
        end
    end

    always @(negedge sck) if (!cs_n && in_frame) begin
        int bi, bt;
        logic [7:0] rb;
        bi = bits / 8; bt = bits % 8; rb = 8'h00;
        if (bi >= 1 && sb[0] == 8'h05) rb = (busy_left > 0) ? 8'h01 : 8'h00;
        else if (bi >= 5 && (sb[0] == 8'h03 || sb[0] == 8'h13))
            rb = rpat({sb[1], sb[2], sb[3], sb[4]}, bi - 5);
        miso_r = rb[7 - bt];
    end

    always @(negedge clk) begin
        if (cs_n) hi_run++;
        else begin
            if (hi_run != 0) last_gap = hi_run;
            hi_run = 0;
        end
    end

    always @(posedge cs_n) if (in_frame) begin
        in_frame = 0;
        frames_seen++;
        if (sb[0] == 8'h05 && sn >= 2) begin
            if (busy_left > 0) busy_left--;
            chk(last_gap >= exp_gap && last_gap <= exp_gap + 1, "R9", "poll gap",
                last_gap, exp_gap);
        end
        if (ex_len.size() == 0) begin
            chk(0, "R11", "unexpected frame opcode", sb[0], 0);
        end else begin
            int l; logic [31:0] h; string t;
            l = ex_len.pop_front(); h = ex_hash.pop_front(); t = ex_tag.pop_front();
            chk(sn == l && sh == h, t, "frame len/hash (op in actual)",
                {sn[15:0], sb[0], 8'h0, sh}, {l[15:0], 16'h0, h});
        end
    end

    always @(negedge clk) if (rd_valid) begin
        if (ex_rd.size() == 0) chk(0, "R8", "unexpected read byte", rd_byte, 0);
        else begin
            logic [7:0] e;
            e = ex_rd.pop_front();
            chk(rd_byte == e, "R8", "read byte", rd_byte, e);
        end
    end

    // driver
    task automatic issue(int kind, bit direct, logic [31:0] a, int len);
        @(negedge clk);
        req_valid = 1'b1; req_kind = 3'(kind); req_direct = direct;
        req_addr = a; req_len = LEN_W'(len);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(output bit e);
        while (!done) @(negedge clk);
        e = err;
        @(negedge clk);
    endtask

    task automatic do_read(bit direct, logic [31:0] a, int len, string tag);
        bit e;
        fr_begin(); fr_add(direct ? 8'h13 : 8'h03); fr_addr(a);
        for (int i = 0; i < len; i++) begin fr_add(8'h00); ex_rd.push_back(rpat(a, i)); end
        fr_push(tag);
        issue(0, direct, a, len);
        chk(busy == 1'b1, "R11", "busy after accept", busy, 1);
        wait_done(e);
        chk(e == 1'b0, tag, "read err", e, 0);
    endtask

    task automatic do_prog(bit direct, logic [31:0] a, int len, string tag);
        bit e;
        for (int i = 0; i < len; i++) pdata[i] = 8'(i * 13 + 5) ^ a[15:8];
        pidx = 0;
        exp_wren("R4");
        fr_begin(); fr_add(direct ? 8'h12 : 8'h02); fr_addr(a);
        for (int i = 0; i < len; i++) fr_add(pdata[i]);
        fr_push(tag);
        issue(1, direct, a, len);
        wait_done(e);
        chk(pidx == len, "R7", "take count", pidx, len);
    endtask

    task automatic do_erase(int kind, bit direct, logic [31:0] a, int polls_busy, string tag);
        bit e;
        logic [7:0] op;
        case (kind)
            2: op = direct ? 8'h21 : 8'h20;
            3: op = direct ? 8'h5C : 8'h52;
            default: op = direct ? 8'hDC : 8'hD8;
        endcase
        exp_gap = (kind == 2) ? PS : PL;
        busy_left = polls_busy;
        exp_wren("R4");
        fr_begin(); fr_add(op); fr_addr(a); fr_push(tag);
        exp_status(polls_busy + 1);
        issue(kind, direct, a, 0);
        wait_done(e);
        chk(e == 1'b0 && busy == 1'b0, "R9", "erase completion", {e, busy}, 0);
    endtask

    task automatic do_reject(int kind, int len, string tag);
        int f0;
        bit e;
        f0 = cs_falls;
        issue(kind, 1'b1, 32'hCAFE0000, len);
        chk(busy == 1'b0, tag, "busy on reject", busy, 0);
        wait_done(e);
        chk(e == 1'b1, tag, "err on reject", e, 1);
        repeat (20) @(negedge clk);
        chk(cs_falls == f0, tag, "cs activity on reject", cs_falls - f0, 0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "R11", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        bit e;
        int f0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(cs_n == 1'b1 && sck == 1'b0, "R12", "cs_n/sck after reset", {cs_n, sck}, 2'b10);
        chk(busy == 1'b0 && done == 1'b0 && err == 1'b0, "R12", "busy/done/err after reset",
            {busy, done, err}, 0);

        do_read(1'b1, 32'h12345678, 4, "R1");      // R1 R3 R8
        do_read(1'b0, 32'h80FF0102, 3, "R2");      // R2 legacy read
        do_read(1'b1, 32'hA5000000, 0, "R8");      // R8 zero length
        do_prog(1'b1, 32'h01020304, 5, "R1");      // R1 R7
        do_prog(1'b0, 32'hFEDC0000, 256, "R2");    // R2 R7 max length
        do_prog(1'b1, 32'h00000010, 1, "R7");      // R7 single byte
        do_reject(1, 0, "R6");                     // R6 zero length
        do_reject(1, 257, "R6");                   // R6 too long
        do_reject(7, 4, "R6");                     // R6 reserved kind
        do_erase(2, 1'b1, 32'h00401000, 2, "R1");  // R1 R9 short interval
        do_erase(3, 1'b0, 32'h10008000, 1, "R2");  // R2 R9 long interval
        do_erase(4, 1'b1, 32'h20010000, 0, "R1");  // R1 64K
        do_erase(4, 1'b0, 32'h30020000, 0, "R2");  // R2 64K
        do_erase(3, 1'b1, 32'h40030000, 0, "R1");  // R1 32K
        do_erase(2, 1'b0, 32'h50041000, 0, "R2");  // R2 4K

        // R5 mode entry, both variants and both set selects
        fr_begin(); fr_add(8'hB7); fr_push("R5");
        issue(5, 1'b0, 32'h0, 0);
        wait_done(e);
        exp_wren("R5");
        fr_begin(); fr_add(8'hB7); fr_push("R5");
        issue(6, 1'b1, 32'h0, 0);
        wait_done(e);

        // R11 request while busy is ignored
        f0 = frames_seen;
        fr_begin(); fr_add(8'h13); fr_addr(32'h00ABCDEF);
        for (int i = 0; i < 2; i++) begin fr_add(8'h00); ex_rd.push_back(rpat(32'h00ABCDEF, i)); end
        fr_push("R11");
        issue(0, 1'b1, 32'h00ABCDEF, 2);
        repeat (10) @(negedge clk);
        req_valid = 1'b1; req_kind = 3'd5;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done(e);
        repeat (60) @(negedge clk);
        chk(frames_seen - f0 == 1, "R11", "frames for one request", frames_seen - f0, 1);

        chk(ex_len.size() == 0, "R4", "missing frames", ex_len.size(), 0);
        chk(ex_rd.size() == 0, "R8", "missing read bytes", ex_rd.size(), 0);
        finish_run();
    end
endmodule